// File: doc/BRIEF.md
# Block Address Translation Lookup

This unit maps a 32-bit effective address onto a physical address through a small set of block mappings, where each mapping is an upper/lower register pair. Every configured pair is compared with the request in parallel. The lowest-numbered valid pair that matches supplies the physical address and the access rights. The unit then checks the requested read, write or execute access against those rights and raises a protection fault when the access is not permitted. A request that matches no valid pair is reported as a miss. Page-table walking and segment translation are not part of this block.

Two register arrays are held, one for instruction fetches and one for data accesses, and the access type picks between them. An input selects how the pair contents are decoded. In the standard layout, the upper word carries the size mask and two privilege-specific valid bits, and the lower word carries a two-bit protection code. In the alternate layout, the lower word carries the size mask and a single valid bit, and the upper word carries two privilege keys and a two-bit protection code. A response is registered and appears one cycle after the request strobe.

Top module: `blk_xlate`

## Requirements
- R1: An entry matches when ea[31:28] equals upper[31:28] and ea[27:17], with the mask bits cleared, equals upper[27:17]. The physical address is {lower[31:28], (ea[27:17] & mask) | lower[27:17], ea[16:0]}.
- R2: In the standard layout (`layout_alt`=0), the 11-bit mask over ea[27:17] is upper[12:2]. Mask bit n covers ea bit 17+n.
- R3: In the standard layout, an entry is valid in supervisor state (`user`=0) when upper[1]=1 and in user state (`user`=1) when upper[0]=1.
- R4: In the standard layout, the protection code lower[1:0] decodes as follows: 0 gives no rights, 2 gives read, write and execute, and 1 or 3 gives read and execute. `rights` is {execute, write, read}, and execute always equals read.
- R5: In the alternate layout (`layout_alt`=1), the mask is {5'b0, lower[5:0]}, so it covers ea[22:17]. Validity is lower[6] in either privilege state.
- R6: In the alternate layout, the key is upper[3] in supervisor state and upper[2] in user state, and the code is upper[1:0]. With key 0, codes 0 to 2 give read and write and code 3 gives read only. With key 1, code 0 gives nothing, codes 1 and 3 give read only, and code 2 gives read and write. Execute follows read.
- R7: A valid match whose rights forbid the requested access (`acc` 0=read, 1=write, 2=execute, 3 treated as read) returns `hit`=1 and `fault`=1.
- R8: When several valid entries match, the lowest index wins. A matching entry that is invalid for the current state is skipped.
- R9: All NUM_ENT entries take part in the lookup, including indices of 4 and above. With NUM_ENT=0, every lookup misses.
- R10: Execute requests use the instruction array and read or write requests use the data array. The write port selects the array with `wr_inst`, the word with `wr_hi` (1=upper), and the entry with `wr_idx`.
- R11: `rsp_valid` is high exactly in the cycle after a cycle with `req` high. `hit`, `fault`, `rights` and `pa` update only on a request. After reset all outputs are 0 and all pairs hold zero.
- R12: A miss returns `hit`=0, `fault`=0, `rights`=0 and `pa`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| layout_alt | input | 1 | 0 = standard pair decoding, 1 = alternate decoding |
| wr_en | input | 1 | Pair register write strobe |
| wr_inst | input | 1 | Write targets the instruction array (1) or the data array (0) |
| wr_hi | input | 1 | Write targets the upper word (1) or the lower word (0) |
| wr_idx | input | IDXW | Entry index for the write |
| wr_data | input | 32 | Write data |
| req | input | 1 | Lookup request strobe |
| ea | input | 32 | Effective address |
| acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| user | input | 1 | Privilege state: 1 user, 0 supervisor |
| rsp_valid | output | 1 | Response valid, one cycle after req |
| hit | output | 1 | A valid entry matched |
| fault | output | 1 | Protection fault on a hit |
| rights | output | 3 | Granted rights {execute, write, read} |
| pa | output | 32 | Physical address |

## Verification
The bench places two valid entries over the same region and confirms that the lower index wins in supervisor state. It then confirms that the higher index takes over in user state, where the lower entry is invalid; a design that picked the last match, or that ignored privilege validity, would return the wrong physical base. A partial size mask is tested on both sides of its boundary, so a mask that is shifted by one bit or inverted would hit where it should miss. An entry at index 5 must hit, which catches a scan stopped at four entries. Execute and data lookups on the same address must return different bases, and the alternate-layout key/code table is tested in both privilege states, so a swapped key bit or a missing valid bit would change the rights or the hit flag.

// File: rtl/blk_xlate.sv
module blk_xlate #(
  parameter int NUM_ENT = 6,
  parameter int IDXW    = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            layout_alt,
  input  logic            wr_en,
  input  logic            wr_inst,
  input  logic            wr_hi,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [31:0]     wr_data,
  input  logic            req,
  input  logic [31:0]     ea,
  input  logic [1:0]      acc,
  input  logic            user,
  output logic            rsp_valid,
  output logic            hit,
  output logic            fault,
  output logic [2:0]      rights,
  output logic [31:0]     pa
);
  localparam int NE = (NUM_ENT > 0) ? NUM_ENT : 1;

  logic [31:0] iu [NE];
  logic [31:0] il [NE];
  logic [31:0] du [NE];
  logic [31:0] dl [NE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) begin
        iu[i] <= '0; il[i] <= '0; du[i] <= '0; dl[i] <= '0;
      end
    end else if (wr_en && (int'(wr_idx) < NE)) begin
      case ({wr_inst, wr_hi})
        2'b11:   iu[wr_idx] <= wr_data;
        2'b10:   il[wr_idx] <= wr_data;
        2'b01:   du[wr_idx] <= wr_data;
        default: dl[wr_idx] <= wr_data;
      endcase
    end
  end

  wire is_exec = (acc == 2'b10);

  logic [31:0] u, l, f_pa;
  logic [10:0] m;
  logic [1:0]  pp;
  logic        v, k, r, w, f_hit;
  logic [2:0]  f_rt;
  logic        unused_bits;

  always_comb begin
    f_hit = 1'b0; f_pa = '0; f_rt = '0;
    u = '0; l = '0; m = '0; pp = '0; v = 1'b0; k = 1'b0; r = 1'b0; w = 1'b0;
    unused_bits = 1'b0;
    for (int i = NE - 1; i >= 0; i--) begin
      u = is_exec ? iu[i] : du[i];
      l = is_exec ? il[i] : dl[i];
      unused_bits = unused_bits ^ (^{u[16:13], l[16:7]});
      if (layout_alt) begin
        m  = {5'b0, l[5:0]};
        v  = l[6];
        k  = user ? u[2] : u[3];
        pp = u[1:0];
        r  = !(k && pp == 2'd0);
        w  = k ? (pp == 2'd2) : (pp != 2'd3);
      end else begin
        m  = u[12:2];
        v  = user ? u[0] : u[1];
        k  = 1'b0;
        pp = l[1:0];
        r  = (pp != 2'd0);
        w  = (pp == 2'd2);
      end
      if (NUM_ENT != 0 && v && ea[31:28] == u[31:28] &&
          (ea[27:17] & ~m) == u[27:17]) begin
        f_hit = 1'b1;
        f_pa  = {l[31:28], (ea[27:17] & m) | l[27:17], ea[16:0]};
        f_rt  = {r, w, r};
      end
    end
  end

  wire allow = (acc == 2'b01) ? f_rt[1] : is_exec ? f_rt[2] : f_rt[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; hit <= 1'b0; fault <= 1'b0; rights <= '0; pa <= '0;
    end else begin
      rsp_valid <= req;
      if (req) begin
        hit    <= f_hit;
        fault  <= f_hit && !allow;
        rights <= f_rt;
        pa     <= f_pa;
      end
    end
  end
endmodule

module blk_xlate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic [1:0] acc,
  input logic       rsp_valid,
  input logic       hit,
  input logic       fault,
  input logic [2:0] rights
);
  assert_resp_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid);
  assert_no_spurious_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rsp_valid);
  assert_fault_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && fault) |-> hit);
  assert_miss_is_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !hit) |-> (rights == 3'b000 && !fault));
  assert_exec_tracks_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rights[2] == rights[0]));
  assert_write_denied_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && hit && !rights[1] && $past(acc) == 2'b01) |-> fault);
endmodule

bind blk_xlate blk_xlate_chk chk_i (.*);

// File: tb/blk_xlate_tb_top.sv
module blk_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        layout_alt = 1'b0;
  logic        wr_en = 1'b0, wr_inst = 1'b0, wr_hi = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        req = 1'b0;
  logic [31:0] ea = '0;
  logic [1:0]  acc = '0;
  logic        user = 1'b0;
  logic        rsp_valid, hit, fault;
  logic [2:0]  rights;
  logic [31:0] pa;
  logic        z_rsp, z_hit, z_fault;
  logic [2:0]  z_rights;
  logic [31:0] z_pa;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  blk_xlate #(.NUM_ENT(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .layout_alt(layout_alt), .wr_en(wr_en),
    .wr_inst(wr_inst), .wr_hi(wr_hi), .wr_idx(wr_idx), .wr_data(wr_data),
    .req(req), .ea(ea), .acc(acc), .user(user), .rsp_valid(rsp_valid),
    .hit(hit), .fault(fault), .rights(rights), .pa(pa));

  blk_xlate #(.NUM_ENT(0)) dut0_i (
    .clk(clk), .rst_n(rst_n), .layout_alt(layout_alt), .wr_en(wr_en),
    .wr_inst(wr_inst), .wr_hi(wr_hi), .wr_idx(wr_idx[0:0]), .wr_data(wr_data),
    .req(req), .ea(ea), .acc(acc), .user(user), .rsp_valid(z_rsp),
    .hit(z_hit), .fault(z_fault), .rights(z_rights), .pa(z_pa));

  // {ea, acc, user, hit, fault, rights, pa, requirement}
  localparam logic [79:0] STD_VEC [13] = '{
    {32'h1001_2345, 2'd0, 1'b0, 1'b1, 1'b0, 3'b111, 32'h8001_2345, 8'd1},  // R1 entry 0
    {32'h1001_2345, 2'd0, 1'b1, 1'b1, 1'b0, 3'b111, 32'h9001_2345, 8'd8},  // R8 invalid e0, e2 wins
    {32'h1002_0000, 2'd0, 1'b0, 1'b0, 1'b0, 3'b000, 32'h0000_0000, 8'd12}, // R12 miss
    {32'h2ABC_DEF0, 2'd1, 1'b1, 1'b1, 1'b1, 3'b101, 32'h3ABC_DEF0, 8'd7},  // R7 write on r-x
    {32'h2ABC_DEF0, 2'd0, 1'b1, 1'b1, 1'b0, 3'b101, 32'h3ABC_DEF0, 8'd3},  // R3 user valid, full mask
    {32'h4000_0010, 2'd0, 1'b0, 1'b1, 1'b1, 3'b000, 32'h5000_0010, 8'd4},  // R4 code 0
    {32'h6000_1000, 2'd0, 1'b0, 1'b1, 1'b0, 3'b111, 32'h7000_1000, 8'd9},  // R9 index 5
    {32'h6000_1000, 2'd2, 1'b0, 1'b1, 1'b0, 3'b101, 32'hA000_1000, 8'd10}, // R10 instruction side
    {32'h6000_1000, 2'd2, 1'b1, 1'b0, 1'b0, 3'b000, 32'h0000_0000, 8'd3},  // R3 user invalid
    {32'h6000_1000, 2'd1, 1'b1, 1'b1, 1'b0, 3'b111, 32'h7000_1000, 8'd10}, // R10 data side write
    {32'h2000_0004, 2'd2, 1'b0, 1'b0, 1'b0, 3'b000, 32'h0000_0000, 8'd10}, // R10 no instr entry
    {32'hC006_1234, 2'd0, 1'b0, 1'b1, 1'b0, 3'b111, 32'hD006_1234, 8'd2},  // R2 inside mask
    {32'hC008_0000, 2'd0, 1'b0, 1'b0, 1'b0, 3'b000, 32'h0000_0000, 8'd2}   // R2 outside mask
  };

  localparam logic [79:0] ALT_VEC [6] = '{
    {32'h1004_0ABC, 2'd1, 1'b0, 1'b1, 1'b0, 3'b111, 32'h8004_0ABC, 8'd6},  // R6 key0 code1
    {32'h1004_0ABC, 2'd1, 1'b1, 1'b1, 1'b1, 3'b101, 32'h8004_0ABC, 8'd6},  // R6 key1 code1
    {32'h1008_0000, 2'd0, 1'b0, 1'b0, 1'b0, 3'b000, 32'h0000_0000, 8'd5},  // R5 beyond mask
    {32'h2000_0100, 2'd0, 1'b0, 1'b1, 1'b1, 3'b000, 32'h3000_0100, 8'd6},  // R6 key1 code0
    {32'h2000_0100, 2'd0, 1'b1, 1'b1, 1'b0, 3'b111, 32'h3000_0100, 8'd6},  // R6 key0 code0
    {32'h4000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 3'b000, 32'h0000_0000, 8'd5}   // R5 valid bit clear
  };

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input bit inst, input bit hi, input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_inst = inst; wr_hi = hi; wr_idx = 3'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_vec(input logic [79:0] v);
    int rq;
    rq = int'(v[7:0]);
    @(negedge clk);
    ea = v[79:48]; acc = v[47:46]; user = v[45]; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(rsp_valid == 1'b1, 11, "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(hit == v[44], rq, "hit", 64'(hit), 64'(v[44]));
    chk(fault == v[43], rq, "fault", 64'(fault), 64'(v[43]));
    chk(rights == v[42:40], rq, "rights", 64'(rights), 64'(v[42:40]));
    chk(pa == v[39:8], rq, "pa", 64'(pa), 64'(v[39:8]));
    chk(z_hit == 1'b0, 9, "empty unit hit", 64'(z_hit), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(rsp_valid == 1'b0 && hit == 1'b0 && fault == 1'b0, 11, "reset outputs",
        64'({rsp_valid, hit, fault}), 64'd0);
    chk(pa == 32'd0 && rights == 3'd0, 11, "reset pa/rights", 64'({rights, pa}), 64'd0);
    rst_n = 1'b1;
    // R11 reset pairs are zero: lookup of address 0 misses
    run_vec({32'h0000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 3'b000, 32'h0, 8'd11});

    wr(0, 1, 0, 32'h1000_0002); wr(0, 0, 0, 32'h8000_0002);
    wr(0, 1, 1, 32'h2000_1FFF); wr(0, 0, 1, 32'h3000_0001);
    wr(0, 1, 2, 32'h1000_0003); wr(0, 0, 2, 32'h9000_0002);
    wr(0, 1, 3, 32'h4000_0003); wr(0, 0, 3, 32'h5000_0000);
    wr(0, 1, 4, 32'hC000_000E); wr(0, 0, 4, 32'hD000_0002);
    wr(0, 1, 5, 32'h6000_0003); wr(0, 0, 5, 32'h7000_0002);
    wr(1, 1, 0, 32'h6000_0002); wr(1, 0, 0, 32'hA000_0001);

    foreach (STD_VEC[i]) run_vec(STD_VEC[i]);

    // R11 outputs hold and rsp_valid drops without a request
    @(negedge clk);
    chk(rsp_valid == 1'b0, 11, "rsp_valid idle", 64'(rsp_valid), 64'd0);
    ea = 32'h1001_2345; user = 1'b0; acc = 2'd0;
    @(negedge clk);
    chk(pa == 32'h0, 11, "pa held without req", 64'(pa), 64'd0);

    layout_alt = 1'b1;
    wr(0, 1, 0, 32'h1000_0005); wr(0, 0, 0, 32'h8000_0043);
    wr(0, 1, 1, 32'h2000_0008); wr(0, 0, 1, 32'h3000_0040);
    foreach (ALT_VEC[i]) run_vec(ALT_VEC[i]);
    // R6 key0 code3: read only, write faults (R7)
    wr(0, 0, 3, 32'h5000_0040);
    run_vec({32'h4000_0000, 2'd1, 1'b0, 1'b1, 1'b1, 3'b101, 32'h5000_0000, 8'd6});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule